// File: doc/BRIEF.md
# Processor Reset Sequencer

This block controls how a processor core enters and leaves reset. An external active-low reset request is passed through a synchronizer that samples it on the falling edge of the bus timing clock. As soon as a low level comes out of the synchronizer, the block asserts core reset. It also holds the interrupt-latch and status clear lines active and forces the bus pins to their idle state: strobes inactive, bus-release output high, address/data drivers floated, and address latch enable high.

When the request goes high again, the core is held in reset for a fixed countdown. After that, reset is released and a one-cycle fetch-start strobe is issued with a fetch address of zero. The block counts how many sampled cycles each request stayed low. It reports through a flag whether the most recent request was shorter than the required minimum.

Top module: `proc_rst_seq`

## Requirements
- R1: While the block's own reset `rst_n` is low, `core_rst_o`, `nmi_clr_o` and `stat_clr_o` are 1, `fetch_go_o` is 0, `short_rst_o` is 0, and the bus pins are in the forced idle state described in R4.
- R2: A low level on `ext_rst_n_i` drives `core_rst_o` to 1 no later than two rising clock edges after it is applied. The delay comes from two falling-edge sampling stages. It does not depend on whether the core is running or counting down.
- R3: `nmi_clr_o` and `stat_clr_o` are 1 exactly while `core_rst_o` is 1, and 0 while the core runs.
- R4: While `core_rst_o` is 1, every bit of `bus_strb_n_o` is 1, `bus_brel_n_o` is 1, `bus_ale_o` is 1 and `bus_addr_oe_o` is 0 (0 means floated). While the core runs, each of these outputs copies its `core_*` input.
- R5: After `ext_rst_n_i` returns high, `core_rst_o` stays 1 for exactly POST_CYC (default 8) rising edges after the synchronizer releases. It then drops to 0, and in that same cycle `fetch_go_o` is 1 for one cycle only, with `fetch_addr_o` equal to 0.
- R6: At each release, `short_rst_o` becomes 1 if the request was seen low for fewer than MIN_LOW (default 64) sampled cycles, and 0 otherwise. It keeps that value until the next release.
- R7: A low request during the post-release countdown returns the block to reset with no fetch strobe. The full countdown restarts after the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus timing clock |
| rst_n | input | 1 | Block power-on reset, active low, asynchronous assert |
| ext_rst_n_i | input | 1 | External reset request, active low |
| core_strb_n_i | input | NSTRB | Core's bus strobe and control levels, active low |
| core_ale_i | input | 1 | Core's address latch enable |
| core_brel_n_i | input | 1 | Core's bus-release output, active low |
| core_addr_oe_i | input | 1 | Core's address/data drive enable |
| core_rst_o | output | 1 | Reset to the core, active high |
| nmi_clr_o | output | 1 | Clear for the edge-triggered NMI latch |
| stat_clr_o | output | 1 | Clear for status word, signal-processing status and clock configuration |
| bus_strb_n_o | output | NSTRB | Bus strobes and controls after forcing |
| bus_ale_o | output | 1 | Address latch enable after forcing |
| bus_brel_n_o | output | 1 | Bus-release output after forcing |
| bus_addr_oe_o | output | 1 | Address/data/space-flag drive enable; 0 means floated |
| fetch_go_o | output | 1 | One-cycle fetch-start strobe |
| fetch_addr_o | output | FETCH_AW | Fetch start address, zero |
| short_rst_o | output | 1 | Last request was shorter than MIN_LOW cycles |

## Verification
Requests of 100, 63 and 64 cycles are applied. The long request confirms the forcing, the clears and the exact countdown length. The 63- and 64-cycle pair sits on both sides of the minimum-length threshold, so an off-by-one in the low counter or in the comparison shows up as a wrong flag. A 70-cycle request is followed by a 3-cycle request that arrives in the middle of the countdown. This separates a design that restarts the countdown from one that lets it finish, and it shows any stray fetch strobe. Power-on with the request already high checks the release path without any external pulse.

// File: rtl/prst_pkg.sv
package prst_pkg;
  typedef enum logic [1:0] {
    PH_HELD  = 2'd0,
    PH_COUNT = 2'd1,
    PH_LIVE  = 2'd2
  } phase_e;
endpackage

// File: rtl/prst_sampler.sv
// Falling-edge synchronizer chain for the external reset request.
module prst_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic low_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], line_n};
  end

  assign low_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/prst_sequencer.sv
module prst_sequencer
  import prst_pkg::*;
#(
  parameter int MIN_LOW  = 64,
  parameter int POST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_low,
  output logic hold_o,
  output logic go_o,
  output logic short_o
);
  localparam int LCW = $clog2(MIN_LOW + 1);
  localparam int DCW = (POST_CYC > 1) ? $clog2(POST_CYC) : 1;
  localparam logic [LCW-1:0] LOW_SAT  = LCW'(MIN_LOW);
  localparam logic [DCW-1:0] DLY_LOAD = DCW'(POST_CYC - 1);

  phase_e         phase_q, phase_d;
  logic [LCW-1:0] lowcnt_q, lowcnt_d;
  logic [DCW-1:0] dly_q, dly_d;
  logic           go_q, go_d;
  logic           short_q, short_d;

  always_comb begin
    phase_d  = phase_q;
    lowcnt_d = lowcnt_q;
    dly_d    = dly_q;
    short_d  = short_q;
    go_d     = 1'b0;
    case (phase_q)
      PH_HELD: begin
        if (smp_low) begin
          if (lowcnt_q != LOW_SAT) lowcnt_d = lowcnt_q + LCW'(1);
        end else begin
          phase_d = PH_COUNT;
          dly_d   = DLY_LOAD;
          short_d = (lowcnt_q < LOW_SAT);
        end
      end
      PH_COUNT: begin
        if (smp_low) begin
          phase_d  = PH_HELD;
          lowcnt_d = LCW'(1);
        end else if (dly_q == '0) begin
          phase_d = PH_LIVE;
          go_d    = 1'b1;
        end else begin
          dly_d = dly_q - DCW'(1);
        end
      end
      PH_LIVE: begin
        if (smp_low) begin
          phase_d  = PH_HELD;
          lowcnt_d = LCW'(1);
        end
      end
      default: phase_d = PH_HELD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HELD;
      lowcnt_q <= '0;
      dly_q    <= '0;
      go_q     <= 1'b0;
      short_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      lowcnt_q <= lowcnt_d;
      dly_q    <= dly_d;
      go_q     <= go_d;
      short_q  <= short_d;
    end
  end

  assign hold_o  = (phase_q != PH_LIVE) | smp_low;
  assign go_o    = go_q;
  assign short_o = short_q;
endmodule

// File: rtl/prst_bus_guard.sv
// Forces bus pins to their idle levels while the core is held in reset.
module prst_bus_guard #(
  parameter int NSTRB = 6
) (
  input  logic             force_i,
  input  logic [NSTRB-1:0] strb_n_i,
  input  logic             ale_i,
  input  logic             brel_n_i,
  input  logic             addr_oe_i,
  output logic [NSTRB-1:0] strb_n_o,
  output logic             ale_o,
  output logic             brel_n_o,
  output logic             addr_oe_o
);
  for (genvar g = 0; g < NSTRB; g++) begin : g_strb
    assign strb_n_o[g] = force_i | strb_n_i[g];
  end
  assign ale_o     = force_i | ale_i;
  assign brel_n_o  = force_i | brel_n_i;
  assign addr_oe_o = ~force_i & addr_oe_i;
endmodule

// File: rtl/proc_rst_seq.sv
module proc_rst_seq #(
  parameter int MIN_LOW     = 64,
  parameter int POST_CYC    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NSTRB       = 6,
  parameter int FETCH_AW    = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_rst_n_i,
  input  logic [NSTRB-1:0]    core_strb_n_i,
  input  logic                core_ale_i,
  input  logic                core_brel_n_i,
  input  logic                core_addr_oe_i,
  output logic                core_rst_o,
  output logic                nmi_clr_o,
  output logic                stat_clr_o,
  output logic [NSTRB-1:0]    bus_strb_n_o,
  output logic                bus_ale_o,
  output logic                bus_brel_n_o,
  output logic                bus_addr_oe_o,
  output logic                fetch_go_o,
  output logic [FETCH_AW-1:0] fetch_addr_o,
  output logic                short_rst_o
);
  logic smp_low;
  logic hold;

  prst_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .line_n(ext_rst_n_i), .low_o(smp_low)
  );

  prst_sequencer #(.MIN_LOW(MIN_LOW), .POST_CYC(POST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .smp_low(smp_low),
    .hold_o(hold), .go_o(fetch_go_o), .short_o(short_rst_o)
  );

  prst_bus_guard #(.NSTRB(NSTRB)) u_guard (
    .force_i(hold), .strb_n_i(core_strb_n_i), .ale_i(core_ale_i),
    .brel_n_i(core_brel_n_i), .addr_oe_i(core_addr_oe_i),
    .strb_n_o(bus_strb_n_o), .ale_o(bus_ale_o),
    .brel_n_o(bus_brel_n_o), .addr_oe_o(bus_addr_oe_o)
  );

  assign core_rst_o   = hold;
  assign nmi_clr_o    = hold;
  assign stat_clr_o   = hold;
  assign fetch_addr_o = '0;
endmodule

module proc_rst_seq_chk #(
  parameter int NSTRB    = 6,
  parameter int FETCH_AW = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                core_rst_o,
  input logic [NSTRB-1:0]    bus_strb_n_o,
  input logic                bus_ale_o,
  input logic                bus_brel_n_o,
  input logic                bus_addr_oe_o,
  input logic                fetch_go_o,
  input logic [FETCH_AW-1:0] fetch_addr_o,
  input logic                short_rst_o
);
  // R5
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go_o |=> !fetch_go_o);
  // R5
  go_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go_o |-> (fetch_addr_o == '0));
  // R5
  go_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go_o |-> (!core_rst_o && $past(core_rst_o)));
  // R4
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> ((&bus_strb_n_o) && bus_ale_o && bus_brel_n_o && !bus_addr_oe_o));
  // R6
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst_o && !$past(core_rst_o)) |-> $stable(short_rst_o));
endmodule

bind proc_rst_seq proc_rst_seq_chk #(.NSTRB(NSTRB), .FETCH_AW(FETCH_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst_o(core_rst_o),
  .bus_strb_n_o(bus_strb_n_o), .bus_ale_o(bus_ale_o),
  .bus_brel_n_o(bus_brel_n_o), .bus_addr_oe_o(bus_addr_oe_o),
  .fetch_go_o(fetch_go_o), .fetch_addr_o(fetch_addr_o),
  .short_rst_o(short_rst_o)
);

// File: tb/proc_rst_seq_test.sv
module proc_rst_seq_test;
  localparam int NSTRB = 6;
  localparam int AW    = 24;
  localparam logic [NSTRB-1:0] STRB_PAT = 6'b010101;

  logic clk = 1'b0;
  logic rst_n, ext_n;
  logic [NSTRB-1:0] strb_n;
  logic ale, brel_n, aoe;
  logic core_rst, nmi_clr, stat_clr, b_ale, b_brel_n, b_aoe, go, short_f;
  logic [NSTRB-1:0] b_strb_n;
  logic [AW-1:0] faddr;

  int n_chk = 0;
  int n_bad = 0;
  int go_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  proc_rst_seq uut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n_i(ext_n),
    .core_strb_n_i(strb_n), .core_ale_i(ale), .core_brel_n_i(brel_n),
    .core_addr_oe_i(aoe), .core_rst_o(core_rst), .nmi_clr_o(nmi_clr),
    .stat_clr_o(stat_clr), .bus_strb_n_o(b_strb_n), .bus_ale_o(b_ale),
    .bus_brel_n_o(b_brel_n), .bus_addr_oe_o(b_aoe), .fetch_go_o(go),
    .fetch_addr_o(faddr), .short_rst_o(short_f)
  );

  always @(negedge clk) if (rst_n === 1'b1 && go === 1'b1) go_cnt++;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_forced(string req);
    chk(req, "core_rst", 32'(core_rst), 1);
    chk(req, "nmi_clr", 32'(nmi_clr), 1);
    chk(req, "stat_clr", 32'(stat_clr), 1);
    chk(req, "strb", 32'(b_strb_n), 32'({NSTRB{1'b1}}));
    chk(req, "ale", 32'(b_ale), 1);
    chk(req, "brel", 32'(b_brel_n), 1);
    chk(req, "addr_oe", 32'(b_aoe), 0);
  endtask

  task automatic chk_running(string req);
    chk(req, "core_rst", 32'(core_rst), 0);
    chk(req, "nmi_clr", 32'(nmi_clr), 0);
    chk(req, "stat_clr", 32'(stat_clr), 0);
    chk(req, "strb", 32'(b_strb_n), 32'(STRB_PAT));
    chk(req, "ale", 32'(b_ale), 0);
    chk(req, "brel", 32'(b_brel_n), 0);
    chk(req, "addr_oe", 32'(b_aoe), 1);
  endtask

  // Called right after ext_n goes high at a tick.
  task automatic release_seq(string req, logic exp_short);
    int g0 = go_cnt;
    repeat (2) tick();
    chk("R6", "short flag", 32'(short_f), 32'(exp_short));
    repeat (7) tick();
    chk(req, "still held before countdown end", 32'(core_rst), 1);
    chk(req, "no early fetch", 32'(go), 0);
    tick();
    chk(req, "fetch strobe", 32'(go), 1);
    chk(req, "fetch addr", 32'(faddr), 0);
    chk_running("R3");
    tick();
    chk(req, "strobe one cycle", 32'(go), 0);
    chk("R4", "pass-through strb", 32'(b_strb_n), 32'(STRB_PAT));
    chk("R5", "one strobe per release", 32'(go_cnt - g0), 1);
    repeat (3) tick();
    chk("R6", "flag held", 32'(short_f), 32'(exp_short));
  endtask

  task automatic t_power_on();
    rst_n = 1'b0; ext_n = 1'b1;
    strb_n = STRB_PAT; ale = 1'b0; brel_n = 1'b0; aoe = 1'b1;
    repeat (3) tick();
    chk_forced("R1");
    chk("R1", "fetch_go", 32'(go), 0);
    chk("R1", "short", 32'(short_f), 0);
    rst_n = 1'b1;
    repeat (20) tick();
    chk("R1", "run after power-on", 32'(core_rst), 0);
    chk("R1", "single power-on fetch", 32'(go_cnt), 1);
  endtask

  task automatic t_long_pulse();
    ext_n = 1'b0;
    tick();
    tick();
    chk("R2", "reset within two edges", 32'(core_rst), 1);
    chk_forced("R3");
    repeat (98) tick();
    chk_forced("R4");
    ext_n = 1'b1;
    release_seq("R5", 1'b0);
  endtask

  task automatic t_pulse(int len, logic exp_short);
    ext_n = 1'b0;
    repeat (len) tick();
    ext_n = 1'b1;
    release_seq("R6", exp_short);
  endtask

  task automatic t_restart();
    int g0;
    ext_n = 1'b0;
    repeat (70) tick();
    ext_n = 1'b1;
    g0 = go_cnt;
    repeat (4) tick();
    chk("R7", "counting down", 32'(core_rst), 1);
    ext_n = 1'b0;
    repeat (3) tick();
    chk("R7", "back in reset", 32'(core_rst), 1);
    chk("R7", "no strobe from aborted countdown", 32'(go_cnt - g0), 0);
    ext_n = 1'b1;
    release_seq("R7", 1'b1);
  endtask

  initial begin
    t_power_on();
    t_long_pulse();
    t_pulse(63, 1'b1);
    t_pulse(64, 1'b0);
    t_pulse(3, 1'b1);
    t_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule